// File: doc/BRIEF.md
# Latched Bus Multiplexer-Demultiplexer

This block joins one narrow port A to two banks, B1 and B2, so that two data paths can share one path. Going from A to the banks, port A feeds two storage latches, one per bank. Each latch has its own load control, so A can place a different word in each bank at a different time, for example to split an address phase from a data phase, or to interleave two memory banks. Each bank has its own active-low drive enable, which also works as bank control.

Going from the banks to A, each bank input has its own storage latch. A select line decides which of the two latched bank words reaches port A, and a separate active-low enable gates port A. Each port models tri-state drive as a data-out word plus a drive indicator.

The latches are emulated on a clock. A latch is transparent while its load control is high, and its stored copy is refreshed on every rising edge while that control stays high. Synchronous reset clears all four stored words.

Top module: `bus_mux_latch`

## Requirements
- R1: After a synchronous reset, with every load control low and every port enabled, A, B1 and B2 all read 0.
- R2: While an A-to-bank load control (`ld_ab1`, `ld_ab2`) is high, that bank's output equals `a_in` in the same cycle.
- R3: After an A-to-bank load control goes low, that bank's output holds the `a_in` value sampled at the last rising edge where the control was high. Later changes on `a_in` are ignored.
- R4: The two A-to-bank latches are independent. Loading or holding one bank never changes the other bank's output.
- R5: `sel` = 0 routes the B1 input latch to `a_out`. `sel` = 1 routes the B2 input latch.
- R6: Each bank input latch (`ld_b1a`, `ld_b2a`) is transparent while its control is high. After the control falls, it holds the bank input sampled at the last rising edge where the control was high.
- R7: The enables `a_en_n`, `b1_en_n` and `b2_en_n` are active low. A disabled port has its drive indicator at 0 and its data parked at 0. An enabled port has its indicator at 1. Disabling a port does not disturb the stored words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for latch emulation |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 12 | Word arriving on port A |
| b1_in | input | 12 | Word arriving on bank B1 |
| b2_in | input | 12 | Word arriving on bank B2 |
| ld_ab1 | input | 1 | Load control, A to B1 latch |
| ld_ab2 | input | 1 | Load control, A to B2 latch |
| ld_b1a | input | 1 | Load control, B1 input latch |
| ld_b2a | input | 1 | Load control, B2 input latch |
| sel | input | 1 | Bank picked onto A (0 = B1, 1 = B2) |
| a_en_n | input | 1 | Active-low drive enable, port A |
| b1_en_n | input | 1 | Active-low drive enable, bank B1 |
| b2_en_n | input | 1 | Active-low drive enable, bank B2 |
| a_out | output | 12 | Data driven onto port A |
| a_oe | output | 1 | Port A is driving |
| b1_out | output | 12 | Data driven onto bank B1 |
| b1_oe | output | 1 | Bank B1 is driving |
| b2_out | output | 12 | Data driven onto bank B2 |
| b2_oe | output | 1 | Bank B2 is driving |

## Verification
Transparency, routing through `sel` and the enables are all combinational. Their results are due in the same cycle as the stimulus, so the bench drives on the falling edge and compares one nanosecond later, before the next rising edge. A held value is due from the cycle after the rising edge that closes the load window. The bench therefore drops a load control one full cycle after presenting the word, and expects the word held at that edge. Every expected item is queued by the driver at the moment of stimulus and popped by the monitor at that mid-cycle point.

// File: rtl/bus_mux_latch_pkg.sv
package bus_mux_latch_pkg;
    localparam int unsigned DEF_WIDTH = 12;
    localparam int unsigned DEF_BANKS = 2;

    typedef enum logic {
        PICK_B1 = 1'b0,
        PICK_B2 = 1'b1
    } pick_e;

    function automatic logic drive_on(input logic en_n);
        return ~en_n;
    endfunction
endpackage

// File: rtl/lat_cell.sv
module lat_cell #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         le,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] held;

    always_ff @(posedge clk) begin
        if (rst)     held <= '0;
        else if (le) held <= d;
    end

    assign q = le ? d : held;

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!le && $past(!le) && !$past(rst)) |-> $stable(q));
    // R6
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(le) && !le && !$past(rst)) |-> (q == $past(d)));
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        ($past(rst) && !rst && !le) |-> (q == '0));
endmodule

// File: rtl/ab_split.sv
module ab_split
    import bus_mux_latch_pkg::*;
#(
    parameter int unsigned W  = 12,
    parameter int unsigned NB = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [W-1:0]         a_i,
    input  logic [NB-1:0]        le_i,
    input  logic [NB-1:0]        en_n_i,
    output logic [NB-1:0][W-1:0] q_o,
    output logic [NB-1:0]        oe_o
);
    for (genvar g = 0; g < NB; g++) begin : g_bank
        logic [W-1:0] lat_q;

        lat_cell #(.W(W)) u_lat (
            .clk (clk),
            .rst (rst),
            .le  (le_i[g]),
            .d   (a_i),
            .q   (lat_q)
        );

        always_comb begin
            oe_o[g] = drive_on(en_n_i[g]);
            q_o[g]  = oe_o[g] ? lat_q : '0;
        end
    end
endmodule

// File: rtl/ba_merge.sv
module ba_merge
    import bus_mux_latch_pkg::*;
#(
    parameter int unsigned W  = 12,
    parameter int unsigned NB = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NB-1:0][W-1:0] b_i,
    input  logic [NB-1:0]        le_i,
    input  pick_e                pick_i,
    input  logic                 en_n_i,
    output logic [W-1:0]         q_o,
    output logic                 oe_o
);
    logic [NB-1:0][W-1:0] lat_q;

    for (genvar g = 0; g < NB; g++) begin : g_in
        lat_cell #(.W(W)) u_lat (
            .clk (clk),
            .rst (rst),
            .le  (le_i[g]),
            .d   (b_i[g]),
            .q   (lat_q[g])
        );
    end

    always_comb begin
        oe_o = drive_on(en_n_i);
        q_o  = '0;
        if (oe_o) q_o = (pick_i == PICK_B2) ? lat_q[1] : lat_q[0];
    end
endmodule

// File: rtl/bus_mux_latch.sv
module bus_mux_latch
    import bus_mux_latch_pkg::*;
#(
    parameter int unsigned W = DEF_WIDTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b1_in,
    input  logic [W-1:0] b2_in,
    input  logic         ld_ab1,
    input  logic         ld_ab2,
    input  logic         ld_b1a,
    input  logic         ld_b2a,
    input  logic         sel,
    input  logic         a_en_n,
    input  logic         b1_en_n,
    input  logic         b2_en_n,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    output logic [W-1:0] b1_out,
    output logic         b1_oe,
    output logic [W-1:0] b2_out,
    output logic         b2_oe
);
    localparam int unsigned NB = DEF_BANKS;

    logic [NB-1:0][W-1:0] bank_q;
    logic [NB-1:0]        bank_oe;
    logic [NB-1:0][W-1:0] bank_in;
    pick_e                pick;

    assign bank_in = {b2_in, b1_in};
    assign pick    = pick_e'(sel);

    ab_split #(.W(W), .NB(NB)) u_split (
        .clk    (clk),
        .rst    (rst),
        .a_i    (a_in),
        .le_i   ({ld_ab2, ld_ab1}),
        .en_n_i ({b2_en_n, b1_en_n}),
        .q_o    (bank_q),
        .oe_o   (bank_oe)
    );

    ba_merge #(.W(W), .NB(NB)) u_merge (
        .clk    (clk),
        .rst    (rst),
        .b_i    (bank_in),
        .le_i   ({ld_b2a, ld_b1a}),
        .pick_i (pick),
        .en_n_i (a_en_n),
        .q_o    (a_out),
        .oe_o   (a_oe)
    );

    assign b1_out = bank_q[0];
    assign b1_oe  = bank_oe[0];
    assign b2_out = bank_q[1];
    assign b2_oe  = bank_oe[1];

    // R5
    a_route_chk: assert property (@(posedge clk) disable iff (rst)
        (a_oe && !sel && ld_b1a) |-> (a_out == b1_in));
    // R2
    b1_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (b1_oe && ld_ab1) |-> (b1_out == a_in));
    // R4
    b2_indep_chk: assert property (@(posedge clk) disable iff (rst)
        (!ld_ab2 && $past(!ld_ab2) && !b2_en_n && $past(!b2_en_n) && !$past(rst))
        |-> $stable(b2_out));
    // R7
    park_chk: assert property (@(posedge clk) disable iff (rst)
        (b1_en_n && b2_en_n) |-> (!b1_oe && !b2_oe && b1_out == '0 && b2_out == '0));
endmodule

// File: tb/bus_mux_latch_tb.sv
module bus_mux_latch_tb;
    localparam int W = 12;

    typedef struct {
        string        req;
        logic [2:0]   oe;   // {a, b1, b2}
        logic [W-1:0] a;
        logic [W-1:0] b1;
        logic [W-1:0] b2;
    } exp_t;

    logic clk = 0;
    logic rst = 1;
    logic [W-1:0] a_in = '0, b1_in = '0, b2_in = '0;
    logic ld_ab1 = 0, ld_ab2 = 0, ld_b1a = 0, ld_b2a = 0, sel = 0;
    logic a_en_n = 0, b1_en_n = 0, b2_en_n = 0;
    logic [W-1:0] a_out, b1_out, b2_out;
    logic a_oe, b1_oe, b2_oe;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;
    exp_t sb[$];
    exp_t item;

    always #2.5 clk = ~clk;

    bus_mux_latch #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .a_in(a_in), .b1_in(b1_in), .b2_in(b2_in),
        .ld_ab1(ld_ab1), .ld_ab2(ld_ab2), .ld_b1a(ld_b1a), .ld_b2a(ld_b2a),
        .sel(sel), .a_en_n(a_en_n), .b1_en_n(b1_en_n), .b2_en_n(b2_en_n),
        .a_out(a_out), .a_oe(a_oe), .b1_out(b1_out), .b1_oe(b1_oe),
        .b2_out(b2_out), .b2_oe(b2_oe)
    );

    task automatic expect_now(input string req, input logic [2:0] oe,
                              input logic [W-1:0] a, input logic [W-1:0] b1,
                              input logic [W-1:0] b2);
        exp_t e;
        e.req = req; e.oe = oe; e.a = a; e.b1 = b1; e.b2 = b2;
        sb.push_back(e);
    endtask

    // Monitor: compares one nanosecond after each falling edge
    always @(negedge clk) begin
        #1;
        if (sb.size() > 0) begin
            item = sb.pop_front();
            tests++;
            if ({a_oe, b1_oe, b2_oe} !== item.oe || a_out !== item.a ||
                b1_out !== item.b1 || b2_out !== item.b2) begin
                fails++;
                $display("FAIL %s: got oe=%b a=%h b1=%h b2=%h, expected oe=%b a=%h b1=%h b2=%h",
                         item.req, {a_oe, b1_oe, b2_oe}, a_out, b1_out, b2_out,
                         item.oe, item.a, item.b1, item.b2);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            fails++;
            $display("FAIL watchdog: got %0d cycles, expected completion", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        rst = 0;
        expect_now("R1 reset", 3'b111, 12'h000, 12'h000, 12'h000);
        @(negedge clk); a_in = 12'h123; ld_ab1 = 1;
        expect_now("R2 b1 transparent", 3'b111, 12'h000, 12'h123, 12'h000);
        @(negedge clk); a_in = 12'h456; ld_ab1 = 0;
        expect_now("R3 b1 hold", 3'b111, 12'h000, 12'h123, 12'h000);
        @(negedge clk); a_in = 12'h789; ld_ab2 = 1;
        expect_now("R4 b2 load, b1 kept", 3'b111, 12'h000, 12'h123, 12'h789);
        @(negedge clk); a_in = 12'hABC; ld_ab2 = 0;
        expect_now("R4 b2 hold", 3'b111, 12'h000, 12'h123, 12'h789);
        @(negedge clk); b1_in = 12'h111; b2_in = 12'h222; ld_b1a = 1; sel = 0;
        expect_now("R6 b1 input transparent", 3'b111, 12'h111, 12'h123, 12'h789);
        @(negedge clk); sel = 1;
        expect_now("R5 sel picks b2 latch", 3'b111, 12'h000, 12'h123, 12'h789);
        @(negedge clk); ld_b1a = 0; ld_b2a = 1;
        expect_now("R5 b2 input routed", 3'b111, 12'h222, 12'h123, 12'h789);
        @(negedge clk); ld_b2a = 0; b1_in = 12'h333; b2_in = 12'h444;
        expect_now("R6 b2 input hold", 3'b111, 12'h222, 12'h123, 12'h789);
        @(negedge clk); sel = 0;
        expect_now("R5 sel back to b1", 3'b111, 12'h111, 12'h123, 12'h789);
        @(negedge clk); a_en_n = 1;
        expect_now("R7 a disabled", 3'b011, 12'h000, 12'h123, 12'h789);
        @(negedge clk); a_en_n = 0; b1_en_n = 1;
        expect_now("R7 b1 disabled", 3'b101, 12'h111, 12'h000, 12'h789);
        @(negedge clk); b1_en_n = 0; b2_en_n = 1;
        expect_now("R7 b2 disabled", 3'b110, 12'h111, 12'h123, 12'h000);
        @(negedge clk); a_en_n = 1; b1_en_n = 1; b2_en_n = 1; a_in = 12'hFFF; ld_ab1 = 1;
        expect_now("R7 all disabled", 3'b000, 12'h000, 12'h000, 12'h000);
        @(negedge clk); a_en_n = 0; b1_en_n = 0; b2_en_n = 0; ld_ab1 = 0;
        expect_now("R3 load while disabled kept", 3'b111, 12'h111, 12'hFFF, 12'h789);
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        expect_now("R1 reset clears all", 3'b111, 12'h000, 12'h000, 12'h000);
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule